// File: doc/BRIEF.md
# Ternary-Coded Divider and Phase Selector

This block derives one bank output clock from a fast phase-generator clock in which every fast cycle is one time unit. A pair of three-level selects picks the divide ratio from a sparse set of nine ratios. A second pair of three-level selects picks a signed start offset, counted in whole time units, measured against a zero-skew reference edge. That reference edge is marked by a one-cycle alignment strobe that several banks share, so that banks with different ratios and offsets keep a fixed phase relation to each other.

Each three-level input arrives as a 2-bit code. Select changes are held off until the next alignment strobe, so reconfiguration never produces a runt pulse. A build parameter selects the extended-range phase table. In that table two codes make the bank copy an offset that a neighbouring bank supplies. A small side decoder reports how many time units fit in one nominal period for a given frequency-range select.

The block has no data stream, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `tdp_divphase_sel`

## Requirements
- R1: After reset `clk_o` and `rise_o` are low, and they stay low until the first `align_i` strobe, whatever the select inputs are.
- R2: The ternary index is 3·hi + lo over the divider pair. Indices 0 to 8 give divide ratios 1, 2, 3, 4, 5, 6, 8, 10 and 12, and `rise_o` pulses once every ratio fast cycles.
- R3: The level encoding is 00 = LOW (digit 0), 01 = MID (digit 1) and 10 = HIGH (digit 2). The illegal code 11 decodes as MID on every select pair.
- R4: Within each divided period `clk_o` is high for ratio/2 fast cycles when the ratio is even and for floor(ratio/2) when it is odd. With ratio 1 it stays high. `rise_o` is high exactly in the first high cycle.
- R5: With the normal table, phase index k selects offset k−4 time units. In the cycle after the strobe edge the output sits at position (−offset) mod ratio of its period (position 0 being the rising cycle). So a zero offset rises at once, +k rises k cycles later and −k rises ratio−k cycles later (modulo ratio).
- R6: With the extended table, phase indices 0, 1, 2, 4, 6, 7 and 8 select −8, −7, −6, 0, +6, +7 and +8 time units.
- R7: With the extended table, phase indices 3 (MID,LOW) and 5 (MID,HIGH) take their offset from `follow_ofs_i`, sampled at the strobe.
- R8: A change of any select between strobes leaves `clk_o` and `rise_o` unaffected until the next strobe applies it.
- R9: `units_o` reports the time units per nominal period: 32 for a frequency select of LOW, 16 for MID (and for 11), and 8 for HIGH.
- R10: A strobe that arrives mid-period restarts the output at the position that R5 gives, discarding the old phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast phase-generator clock, one time unit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| align_i | input | 1 | One-cycle zero-skew alignment strobe |
| div_hi_i | input | 2 | Divider select, high ternary digit |
| div_lo_i | input | 2 | Divider select, low ternary digit |
| ph_hi_i | input | 2 | Phase select, high ternary digit |
| ph_lo_i | input | 2 | Phase select, low ternary digit |
| follow_ofs_i | input | OW (5) | Signed offset copied from the neighbouring bank in follow codes |
| fsel_i | input | 2 | Three-level frequency-range select |
| clk_o | output | 1 | Divided, phase-shifted bank clock |
| rise_o | output | 1 | One-cycle marker of each rising edge of `clk_o` |
| units_o | output | 6 | Time units per nominal period |

## Verification
The hardest case to reach is a select change that lands between strobes while the output is running. If it were applied early, it would show up only as a subtle shift in period or phase. The bench aligns one configuration and checks part of a period. It then alters both select pairs on a falling edge without a strobe and keeps comparing against the old configuration for several full periods. Only after that does it strobe and check the new one. Negative offsets larger than the ratio, such as −4 at ratio 3, get separate windows to exercise the modulo wrap.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

  // Ternary digit value of one 2-bit level code; illegal 11 folds to MID.
  function automatic logic [1:0] lvl_digit(input logic [1:0] code);
    return (code == 2'b11) ? 2'd1 : code;
  endfunction

  // Two-digit ternary index 3*hi + lo, range 0..8.
  function automatic logic [3:0] tern_idx(input logic [1:0] hi, input logic [1:0] lo);
    logic [3:0] h;
    logic [3:0] l;
    h = {2'b00, lvl_digit(hi)};
    l = {2'b00, lvl_digit(lo)};
    return (h * 4'd3) + l;
  endfunction

  // Time units contained in one nominal period for a frequency-range select.
  function automatic logic [5:0] units_per_nom(input logic [1:0] fs);
    case (lvl_digit(fs))
      2'd0:    return 6'd32;
      2'd2:    return 6'd8;
      default: return 6'd16;
    endcase
  endfunction

  // Counter position right after the strobe: (-ofs) mod period.
  function automatic int start_pos(input int per, input int ofs);
    int p;
    int v;
    p = (per < 1) ? 1 : per;
    v = (-ofs) % p;
    if (v < 0) v = v + p;
    return v;
  endfunction

endpackage

// File: rtl/tdp_ratio_dec.sv
module tdp_ratio_dec #(
  parameter int CW = 4
) (
  input  logic [1:0]    sel_hi_i,
  input  logic [1:0]    sel_lo_i,
  output logic [CW-1:0] ratio_o,
  output logic [CW-1:0] high_len_o
);
  import tdp_pkg::*;

  logic [3:0] idx;

  always_comb begin
    idx = tern_idx(sel_hi_i, sel_lo_i);
    case (idx)
      4'd0:    ratio_o = CW'(1);
      4'd1:    ratio_o = CW'(2);
      4'd2:    ratio_o = CW'(3);
      4'd3:    ratio_o = CW'(4);
      4'd4:    ratio_o = CW'(5);
      4'd5:    ratio_o = CW'(6);
      4'd6:    ratio_o = CW'(8);
      4'd7:    ratio_o = CW'(10);
      4'd8:    ratio_o = CW'(12);
      default: ratio_o = CW'(1);
    endcase
    // ratio 1 cannot toggle inside a fast cycle, so it is held high
    high_len_o = (ratio_o == CW'(1)) ? CW'(1) : (ratio_o >> 1);
  end

endmodule

// File: rtl/tdp_phase_dec.sv
module tdp_phase_dec #(
  parameter bit EXT = 1'b0,
  parameter int OW  = 5
) (
  input  logic [1:0]           sel_hi_i,
  input  logic [1:0]           sel_lo_i,
  input  logic signed [OW-1:0] follow_i,
  output logic signed [OW-1:0] ofs_o
);
  import tdp_pkg::*;

  logic [3:0] idx;
  assign idx = tern_idx(sel_hi_i, sel_lo_i);

  generate
    if (EXT) begin : g_ext
      always_comb begin
        case (idx)
          4'd0:    ofs_o = -OW'(8);
          4'd1:    ofs_o = -OW'(7);
          4'd2:    ofs_o = -OW'(6);
          4'd3:    ofs_o = follow_i;
          4'd5:    ofs_o = follow_i;
          4'd6:    ofs_o = OW'(6);
          4'd7:    ofs_o = OW'(7);
          4'd8:    ofs_o = OW'(8);
          default: ofs_o = '0;
        endcase
      end
    end else begin : g_norm
      always_comb ofs_o = $signed({{(OW-4){1'b0}}, idx}) - OW'(4);
    end
  endgenerate

endmodule

// File: rtl/tdp_phase_core.sv
module tdp_phase_core #(
  parameter int CW = 4,
  parameter int OW = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 align_i,
  input  logic [CW-1:0]        ratio_i,
  input  logic [CW-1:0]        high_len_i,
  input  logic signed [OW-1:0] ofs_i,
  output logic                 clk_o,
  output logic                 rise_o
);
  import tdp_pkg::*;

  logic [CW-1:0] per_r, hl_r, cnt_r, cnt_nx, start_w;
  logic          run_r, q_r, rise_r;

  always_comb begin
    start_w = CW'(start_pos(int'(ratio_i), int'(ofs_i)));
    cnt_nx  = (cnt_r == per_r - CW'(1)) ? '0 : cnt_r + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_r  <= CW'(1);
      hl_r   <= CW'(1);
      cnt_r  <= '0;
      run_r  <= 1'b0;
      q_r    <= 1'b0;
      rise_r <= 1'b0;
    end else if (align_i) begin
      per_r  <= ratio_i;
      hl_r   <= high_len_i;
      cnt_r  <= start_w;
      run_r  <= 1'b1;
      q_r    <= (start_w < high_len_i);
      rise_r <= (start_w == '0);
    end else if (run_r) begin
      cnt_r  <= cnt_nx;
      q_r    <= (cnt_nx < hl_r);
      rise_r <= (cnt_nx == '0);
    end
  end

  assign clk_o  = q_r;
  assign rise_o = rise_r;

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !align_i |=> ($stable(per_r) && $stable(hl_r)));

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_r |-> (cnt_r < per_r));

  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_r |-> (!q_r && !rise_r));

  // R4
  rise_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_r |-> q_r);

  // R2
  rise_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_r && !align_i && per_r != CW'(1)) |=> !rise_r);

endmodule

// File: rtl/tdp_divphase_sel.sv
module tdp_divphase_sel #(
  parameter int CW        = 4,
  parameter int OW        = 5,
  parameter bit EXT_PHASE = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 align_i,
  input  logic [1:0]           div_hi_i,
  input  logic [1:0]           div_lo_i,
  input  logic [1:0]           ph_hi_i,
  input  logic [1:0]           ph_lo_i,
  input  logic signed [OW-1:0] follow_ofs_i,
  input  logic [1:0]           fsel_i,
  output logic                 clk_o,
  output logic                 rise_o,
  output logic [5:0]           units_o
);
  import tdp_pkg::*;

  logic [CW-1:0]        ratio_w, hlen_w;
  logic signed [OW-1:0] ofs_w;

  tdp_ratio_dec #(.CW(CW)) u_ratio (
    .sel_hi_i   (div_hi_i),
    .sel_lo_i   (div_lo_i),
    .ratio_o    (ratio_w),
    .high_len_o (hlen_w)
  );

  tdp_phase_dec #(.EXT(EXT_PHASE), .OW(OW)) u_phase (
    .sel_hi_i (ph_hi_i),
    .sel_lo_i (ph_lo_i),
    .follow_i (follow_ofs_i),
    .ofs_o    (ofs_w)
  );

  tdp_phase_core #(.CW(CW), .OW(OW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .align_i    (align_i),
    .ratio_i    (ratio_w),
    .high_len_i (hlen_w),
    .ofs_i      (ofs_w),
    .clk_o      (clk_o),
    .rise_o     (rise_o)
  );

  assign units_o = units_per_nom(fsel_i);

  // R9
  units_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(units_o) && (units_o[5] || units_o[4] || units_o[3]));

endmodule

// File: tb/tdp_divphase_sel_test.sv
`timescale 1ns/1ps
module tdp_divphase_sel_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic align = 1'b0;
  logic [1:0] div_hi = 2'b01, div_lo = 2'b01, ph_hi = 2'b01, ph_lo = 2'b01, fsel = 2'b00;
  logic signed [4:0] follow = '0;
  logic clk_n, rise_n, clk_x, rise_x;
  logic [5:0] units_n, units_x;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tdp_divphase_sel #(.EXT_PHASE(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .align_i(align), .div_hi_i(div_hi), .div_lo_i(div_lo),
    .ph_hi_i(ph_hi), .ph_lo_i(ph_lo), .follow_ofs_i(follow), .fsel_i(fsel),
    .clk_o(clk_n), .rise_o(rise_n), .units_o(units_n));

  tdp_divphase_sel #(.EXT_PHASE(1'b1)) uut_x (
    .clk_i(clk), .rst_ni(rst_n), .align_i(align), .div_hi_i(div_hi), .div_lo_i(div_lo),
    .ph_hi_i(ph_hi), .ph_lo_i(ph_lo), .follow_ofs_i(follow), .fsel_i(fsel),
    .clk_o(clk_x), .rise_o(rise_x), .units_o(units_x));

  function automatic logic [1:0] enc(input int d);
    return (d == 0) ? 2'b00 : (d == 1) ? 2'b01 : 2'b10;
  endfunction

  function automatic int ratio_of(input int idx);
    int tbl[9] = '{1, 2, 3, 4, 5, 6, 8, 10, 12};
    return tbl[idx];
  endfunction

  function automatic int ext_ofs(input int idx, input int fol);
    int tbl[9] = '{-8, -7, -6, 0, 0, 0, 6, 7, 8};
    return (idx == 3 || idx == 5) ? fol : tbl[idx];
  endfunction

  task automatic set_codes(input int didx, input int pidx);
    div_hi = enc(didx / 3); div_lo = enc(didx % 3);
    ph_hi  = enc(pidx / 3); ph_lo  = enc(pidx % 3);
  endtask

  task automatic strobe();
    align = 1'b1;
    @(posedge clk);
    @(negedge clk);
    align = 1'b0;
  endtask

  // compares n cycles, i0 cycles after the strobe edge
  task automatic check_win(input string tag, input int p, input int off, input int i0,
                           input int n, input bit ext);
    int st, hl, bad;
    logic eq, er, aq, ar;
    st = (-off) % p;
    if (st < 0) st = st + p;
    hl = (p == 1) ? 1 : p / 2;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      int pos;
      pos = (st + i0 + i) % p;
      eq = (pos < hl);
      er = (pos == 0);
      aq = ext ? clk_x : clk_n;
      ar = ext ? rise_x : rise_n;
      if ((aq !== eq || ar !== er) && bad == 0) begin
        $display("FAIL %s cycle %0d: clk,rise actual %b%b expected %b%b", tag, i0 + i, aq, ar, eq, er);
        bad = 1;
      end
      @(negedge clk);
    end
    tests++;
    if (bad != 0) fails++;
  endtask

  task automatic t_reset();  // R1
    int bad = 0;
    set_codes(6, 2);
    for (int i = 0; i < 20; i++) begin
      if (clk_n !== 1'b0 || rise_n !== 1'b0 || clk_x !== 1'b0 || rise_x !== 1'b0) bad = 1;
      @(negedge clk);
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R1 idle output: actual %b%b%b%b expected 0000", clk_n, rise_n, clk_x, rise_x);
    end
  endtask

  task automatic t_div();  // R2 R4
    for (int d = 0; d < 9; d++) begin
      set_codes(d, 4);
      strobe();
      check_win($sformatf("R2/R4 ratio idx %0d", d), ratio_of(d), 0, 0, 2 * ratio_of(d) + 2, 1'b0);
    end
  endtask

  task automatic t_phase();  // R5
    for (int k = 0; k < 9; k++) begin
      set_codes(6, k);
      strobe();
      check_win($sformatf("R5 phase idx %0d", k), 8, k - 4, 0, 18, 1'b0);
    end
    set_codes(2, 0); strobe(); check_win("R5 ratio3 offset -4", 3, -4, 0, 8, 1'b0);
    set_codes(2, 8); strobe(); check_win("R5 ratio3 offset +4", 3, 4, 0, 8, 1'b0);
  endtask

  task automatic t_illegal();  // R3
    div_hi = 2'b11; div_lo = 2'b11; ph_hi = 2'b11; ph_lo = 2'b10;
    strobe();
    check_win("R3 illegal codes as MID", 5, 1, 0, 12, 1'b0);
  endtask

  task automatic t_ext();  // R6
    int ks[7] = '{0, 1, 2, 4, 6, 7, 8};
    foreach (ks[j]) begin
      set_codes(8, ks[j]);
      strobe();
      check_win($sformatf("R6 ext idx %0d", ks[j]), 12, ext_ofs(ks[j], 0), 0, 26, 1'b1);
    end
  endtask

  task automatic t_follow();  // R7
    follow = -5'sd3; set_codes(7, 3); strobe();
    check_win("R7 follow ML -3", 10, -3, 0, 22, 1'b1);
    follow = 5'sd5; set_codes(7, 5); strobe();
    follow = 5'sd1;
    check_win("R7 follow MH +5", 10, 5, 0, 22, 1'b1);
  endtask

  task automatic t_hold();  // R8
    set_codes(5, 4);
    strobe();
    check_win("R8 before change", 6, 0, 0, 4, 1'b0);
    set_codes(3, 6);
    check_win("R8 change held off", 6, 0, 4, 20, 1'b0);
    strobe();
    check_win("R8 applied at strobe", 4, 2, 0, 10, 1'b0);
  endtask

  task automatic t_realign();  // R10
    set_codes(4, 4);
    strobe();
    check_win("R10 before realign", 5, 0, 0, 7, 1'b0);
    set_codes(4, 6);
    strobe();
    check_win("R10 realign +2", 5, 2, 0, 12, 1'b0);
  endtask

  task automatic t_units();  // R9
    logic [1:0] fs[4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    int ex[4] = '{32, 16, 8, 16};
    foreach (fs[j]) begin
      fsel = fs[j];
      @(negedge clk);
      tests++;
      if (int'(units_n) != ex[j]) begin
        fails++;
        $display("FAIL R9 fsel %b: actual %0d expected %0d", fs[j], units_n, ex[j]);
      end
    end
  endtask

  initial begin
    #2000000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_div();
    t_phase();
    t_illegal();
    t_ext();
    t_follow();
    t_hold();
    t_realign();
    t_units();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule